// File: doc/BRIEF.md
# Eight-Bit Timer with Compare-Match Waveform Output

This block is an 8-bit timer/counter. It advances once for each pulse on its count-enable input. That input is meant to be driven by a prescaled tick produced elsewhere. Software sets the block up through a small register port with synchronous writes and combinational reads. Through that port it picks the counting mode, sets compare register A, picks the pin action taken on a compare match, and loads the counter directly.

There are two counting modes. In free-running mode the counter wraps from 0xFF to 0x00. In clear-on-compare mode the counter returns to zero after it reaches the value held in compare register A.

An overflow flag and a compare flag record events. Each flag drives an interrupt line through its own enable bit. Each flag is cleared by an acknowledge input or by writing a one to its bit. A single waveform pin can be toggled, cleared or set on each compare match. A force strobe applies the same pin action at once, without waiting for a match.

Top module: `tmr8_top`

Register map, with addresses on `bus_addr_i`:

| Address | Contents |
|---------|----------|
| 0 | Control: bits [2:0] select the mode, bits [5:4] select the pin action, bit 7 is the force strobe (write-only, reads as 0) |
| 1 | Counter value |
| 2 | Compare register A |
| 3 | Flags: bit 0 is overflow, bit 1 is compare |
| 4 | Interrupt enables: bit 0 is overflow, bit 1 is compare |

Any other address reads as 0.

## Requirements
- R1: After reset, the counter, compare register A, both flags and the waveform pin are 0.
- R2: With any mode value other than 2, each tick adds one to the counter. The counter wraps from 0xFF to 0x00 and is never cleared by a compare match.
- R3: The overflow flag (address 3, bit 0) is set by the tick that takes the counter from 0xFF to 0x00. The flag stays set on later ticks until software clears it.
- R4: With mode value 2 (clear-on-compare), a tick that finds the counter equal to compare register A loads 0 into the counter instead of adding one.
- R5: Each tick that finds the counter equal to compare register A is a match. A match sets the compare flag (address 3, bit 1) in either mode.
- R6: On a match, the pin action field (control bits [5:4]) selects the change to the waveform pin: 0 leaves it unchanged, 1 toggles it, 2 drives it to 0, 3 drives it to 1. Writing a new action does not change the pin until the next match.
- R7: Writing control bit 7 as 1 applies the action in that same write's bits [5:4] to the pin at once. It does not set the compare flag and does not change the counter. Bit 7 reads back as 0.
- R8: A counter write wins over a tick in the same cycle. The first tick after a counter write produces no match.
- R9: A flag is cleared by its acknowledge input or by writing a one to its bit at address 3. A hardware set in the same cycle wins over the clear.
- R10: Each interrupt output is high exactly when its flag is set and its enable bit at address 4 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the prescaler |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| ovf_ack_i | input | 1 | Acknowledge of the overflow interrupt |
| cmp_ack_i | input | 1 | Acknowledge of the compare interrupt |
| ovf_irq_o | output | 1 | Overflow interrupt |
| cmp_irq_o | output | 1 | Compare interrupt |
| wave_o | output | 1 | Waveform pin |

## Verification
The assertions assume that `tick_i`, `bus_wr_i` and the acknowledge inputs are synchronous single-cycle pulses. They also assume these inputs are driven to 0 during reset, so every step they check begins from a registered counter value. The bench changes inputs only on falling edges and releases each strobe after one cycle, so every write and tick is seen at exactly one rising edge. The only case where a tick and a counter write share an edge is the one that is deliberate, used to check that the write wins.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'd0,
        PIN_TOGGLE = 2'd1,
        PIN_LOW    = 2'd2,
        PIN_HIGH   = 2'd3
    } pin_act_e;

    localparam logic [2:0] MODE_CLR_ON_CMP = 3'd2;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_COUNT = 3'd1;
    localparam logic [2:0] A_CMPA  = 3'd2;
    localparam logic [2:0] A_FLAGS = 3'd3;
    localparam logic [2:0] A_IEN   = 3'd4;

    localparam int unsigned FORCE_BIT = 7;

endpackage

// File: rtl/tmr8_count.sv
module tmr8_count
    import tmr8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [2:0]   mode_i,
    input  logic [W-1:0] top_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         match_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         blk;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       match_d, wrap_d;

    always_comb begin
        st_d    = st_q;
        match_d = 1'b0;
        wrap_d  = 1'b0;
        if (wr_i) begin
            st_d.cnt = wdata_i;
            st_d.blk = 1'b1;
        end else if (tick_i) begin
            st_d.blk = 1'b0;
            match_d  = !st_q.blk && (st_q.cnt == top_i);
            wrap_d   = (st_q.cnt == CNT_MAX);
            if ((mode_i == MODE_CLR_ON_CMP) && match_d) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign match_o = match_d;
    assign wrap_o  = wrap_d;

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_i && mode_i != MODE_CLR_ON_CMP) |=> cnt_o == W'($past(cnt_o) + 1'b1)); // R2

    AST_CLR_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_i && mode_i == MODE_CLR_ON_CMP && !st_q.blk && cnt_o == top_i) |=> cnt_o == '0); // R4

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> cnt_o == $past(wdata_i)); // R8

endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
    import tmr8_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          ovf_set_i,
    input  logic          cmp_set_i,
    input  logic          ovf_ack_i,
    input  logic          cmp_ack_i,
    output logic [2:0]    mode_o,
    output logic [1:0]    act_o,
    output logic [W-1:0]  top_o,
    output logic [1:0]    ien_o,
    output logic          ovf_flag_o,
    output logic          cmp_flag_o,
    output logic          cnt_wr_o,
    output logic          force_o,
    output logic [1:0]    force_act_o
);

    typedef struct packed {
        logic [2:0]   mode;
        logic [1:0]   act;
        logic [W-1:0] top;
        logic [1:0]   ien;
        logic         ovf;
        logic         cmp;
    } reg_state_t;

    reg_state_t rs_d, rs_q;
    logic       hit_ctrl, hit_flags;

    always_comb begin
        rs_d      = rs_q;
        hit_ctrl  = wr_i && (addr_i == AW'(A_CTRL));
        hit_flags = wr_i && (addr_i == AW'(A_FLAGS));
        if (hit_ctrl) begin
            rs_d.mode = wdata_i[2:0];
            rs_d.act  = wdata_i[5:4];
        end
        if (wr_i && (addr_i == AW'(A_CMPA))) rs_d.top = wdata_i;
        if (wr_i && (addr_i == AW'(A_IEN)))  rs_d.ien = wdata_i[1:0];
        if (ovf_ack_i || (hit_flags && wdata_i[0])) rs_d.ovf = 1'b0;
        if (cmp_ack_i || (hit_flags && wdata_i[1])) rs_d.cmp = 1'b0;
        if (ovf_set_i) rs_d.ovf = 1'b1;
        if (cmp_set_i) rs_d.cmp = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign mode_o      = rs_q.mode;
    assign act_o       = rs_q.act;
    assign top_o       = rs_q.top;
    assign ien_o       = rs_q.ien;
    assign ovf_flag_o  = rs_q.ovf;
    assign cmp_flag_o  = rs_q.cmp;
    assign cnt_wr_o    = wr_i && (addr_i == AW'(A_COUNT));
    assign force_o     = hit_ctrl && wdata_i[FORCE_BIT];
    assign force_act_o = wdata_i[5:4];

    AST_OVF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set_i |=> ovf_flag_o); // R3

    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !ovf_ack_i && !(wr_i && addr_i == AW'(A_FLAGS))) |=> ovf_flag_o); // R3

    AST_CMP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_set_i |=> cmp_flag_o); // R5

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
    import tmr8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_i,
    input  logic [1:0] act_i,
    input  logic       force_i,
    input  logic [1:0] force_act_i,
    output logic       wave_o
);

    typedef struct packed {
        logic pin;
    } wave_state_t;

    wave_state_t ws_d, ws_q;
    pin_act_e    sel;

    always_comb begin
        ws_d = ws_q;
        sel  = pin_act_e'(force_i ? force_act_i : act_i);
        if (force_i || match_i) begin
            case (sel)
                PIN_TOGGLE: ws_d.pin = !ws_q.pin;
                PIN_LOW:    ws_d.pin = 1'b0;
                PIN_HIGH:   ws_d.pin = 1'b1;
                default:    ws_d.pin = ws_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q <= '0;
        end else begin
            ws_q <= ws_d;
        end
    end

    assign wave_o = ws_q.pin;

    AST_KEEP_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !force_i && act_i == 2'd0) |=> $stable(wave_o)); // R6

    AST_FORCE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && force_act_i == 2'd1) |=> wave_o != $past(wave_o)); // R7

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_i && !force_i) |=> $stable(wave_o)); // R6

endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
    import tmr8_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [W-1:0]  bus_wdata_i,
    output logic [W-1:0]  bus_rdata_o,
    input  logic          ovf_ack_i,
    input  logic          cmp_ack_i,
    output logic          ovf_irq_o,
    output logic          cmp_irq_o,
    output logic          wave_o
);

    logic [2:0]   mode;
    logic [1:0]   act;
    logic [W-1:0] top;
    logic [1:0]   ien;
    logic         ovf_flag, cmp_flag;
    logic         cnt_wr, force_strobe;
    logic [1:0]   force_act;
    logic [W-1:0] cnt;
    logic         match, wrap;

    tmr8_regs #(.W(W), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wr_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .ovf_set_i   (wrap),
        .cmp_set_i   (match),
        .ovf_ack_i   (ovf_ack_i),
        .cmp_ack_i   (cmp_ack_i),
        .mode_o      (mode),
        .act_o       (act),
        .top_o       (top),
        .ien_o       (ien),
        .ovf_flag_o  (ovf_flag),
        .cmp_flag_o  (cmp_flag),
        .cnt_wr_o    (cnt_wr),
        .force_o     (force_strobe),
        .force_act_o (force_act)
    );

    tmr8_count #(.W(W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .mode_i  (mode),
        .top_i   (top),
        .wr_i    (cnt_wr),
        .wdata_i (bus_wdata_i),
        .cnt_o   (cnt),
        .match_o (match),
        .wrap_o  (wrap)
    );

    tmr8_wave u_wave (
        .clk         (clk),
        .rst_n       (rst_n),
        .match_i     (match),
        .act_i       (act),
        .force_i     (force_strobe),
        .force_act_i (force_act),
        .wave_o      (wave_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            AW'(A_CTRL):  bus_rdata_o = W'({act, 1'b0, mode});
            AW'(A_COUNT): bus_rdata_o = cnt;
            AW'(A_CMPA):  bus_rdata_o = top;
            AW'(A_FLAGS): bus_rdata_o = W'({cmp_flag, ovf_flag});
            AW'(A_IEN):   bus_rdata_o = W'(ien);
            default:      bus_rdata_o = '0;
        endcase
    end

    assign ovf_irq_o = ovf_flag && ien[0];
    assign cmp_irq_o = cmp_flag && ien[1];

    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (force_strobe && !tick_i && !cmp_flag) |=> !cmp_flag); // R7

    AST_BLOCKED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !cmp_flag) ##1 (tick_i && !bus_wr_i && !cmp_ack_i) |=> !cmp_flag); // R8

endmodule

// File: tb/sim_tmr8_top.sv
module sim_tmr8_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ovf_ack = 1'b0;
    logic       cmp_ack = 1'b0;
    logic       ovf_irq, cmp_irq, wave;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tmr8_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_wr_i    (wr_en),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .ovf_ack_i   (ovf_ack),
        .cmp_ack_i   (cmp_ack),
        .ovf_irq_o   (ovf_irq),
        .cmp_irq_o   (cmp_irq),
        .wave_o      (wave)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v == e, req, int'(v), int'(e));
    endtask

    task automatic t_reset;
        expect_reg(3'd1, 8'h00, "R1 count");
        expect_reg(3'd2, 8'h00, "R1 cmpa");
        expect_reg(3'd3, 8'h00, "R1 flags");
        check(wave == 1'b0, "R1 wave", int'(wave), 0);
    endtask

    task automatic t_free_run;
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h05);
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h03);
        ticks(3);
        expect_reg(3'd1, 8'h06, "R2 passes cmpa without clear");
        expect_reg(3'd3, 8'h02, "R5 cmp flag in free mode");
        wr(3'd1, 8'hFE);
        ticks(1);
        expect_reg(3'd3, 8'h02, "R3 no overflow at FF");
        ticks(1);
        expect_reg(3'd1, 8'h00, "R2 wrap to zero");
        expect_reg(3'd3, 8'h03, "R3 overflow set on wrap");
        ticks(1);
        expect_reg(3'd3, 8'h03, "R3 overflow stays set");
        wr(3'd0, 8'h04);
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h04);
        ticks(2);
        expect_reg(3'd1, 8'h06, "R2 mode 4 acts as free running");
        expect_reg(3'd3, 8'h02, "R5 match in mode 4");
    endtask

    task automatic t_clear_on_cmp;
        wr(3'd0, 8'h12);
        wr(3'd2, 8'h03);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h03);
        ticks(3);
        expect_reg(3'd1, 8'h03, "R4 reaches top");
        check(wave == 1'b0, "R6 no toggle before match", int'(wave), 0);
        ticks(1);
        expect_reg(3'd1, 8'h00, "R4 clears at top");
        check(wave == 1'b1, "R6 toggle on match", int'(wave), 1);
        expect_reg(3'd3, 8'h02, "R5 cmp flag at top");
        ticks(4);
        expect_reg(3'd1, 8'h00, "R4 second period");
        check(wave == 1'b0, "R6 toggle back", int'(wave), 0);
    endtask

    task automatic t_actions;
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h32);
        wr(3'd1, 8'h00);
        ticks(2);
        check(wave == 1'b1, "R6 set action", int'(wave), 1);
        wr(3'd0, 8'h22);
        check(wave == 1'b1, "R6 new action waits for match", int'(wave), 1);
        ticks(2);
        check(wave == 1'b0, "R6 clear action", int'(wave), 0);
        wr(3'd0, 8'h32);
        ticks(2);
        wr(3'd0, 8'h02);
        ticks(2);
        check(wave == 1'b1, "R6 keep action", int'(wave), 1);
        expect_reg(3'd1, 8'h00, "R4 top of one");
    endtask

    task automatic t_force;
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h92);
        check(wave == 1'b0, "R7 forced toggle", int'(wave), 0);
        expect_reg(3'd3, 8'h00, "R7 no flag on force");
        expect_reg(3'd1, 8'h00, "R7 counter untouched");
        expect_reg(3'd0, 8'h12, "R7 strobe reads zero");
        wr(3'd0, 8'hB2);
        check(wave == 1'b1, "R7 forced set", int'(wave), 1);
        wr(3'd0, 8'hA2);
        check(wave == 1'b0, "R7 forced clear", int'(wave), 0);
    endtask

    task automatic t_block;
        wr(3'd0, 8'h02);
        wr(3'd2, 8'h04);
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h04);
        ticks(1);
        expect_reg(3'd1, 8'h05, "R8 blocked match no clear");
        expect_reg(3'd3, 8'h00, "R8 blocked match no flag");
        @(negedge clk);
        addr  = 3'd1;
        wdata = 8'h20;
        wr_en = 1'b1;
        tick  = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        tick  = 1'b0;
        expect_reg(3'd1, 8'h20, "R8 write beats tick");
    endtask

    task automatic t_flags;
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h01);
        wr(3'd3, 8'h03);
        wr(3'd1, 8'hFF);
        ticks(1);
        check(ovf_irq == 1'b1, "R10 overflow irq", int'(ovf_irq), 1);
        @(negedge clk);
        ovf_ack = 1'b1;
        @(negedge clk);
        ovf_ack = 1'b0;
        expect_reg(3'd3, 8'h00, "R9 ack clears overflow");
        check(ovf_irq == 1'b0, "R10 irq drops", int'(ovf_irq), 0);
        wr(3'd2, 8'h02);
        wr(3'd1, 8'h01);
        ticks(2);
        check(cmp_irq == 1'b0, "R10 cmp irq masked", int'(cmp_irq), 0);
        wr(3'd4, 8'h02);
        check(cmp_irq == 1'b1, "R10 cmp irq enabled", int'(cmp_irq), 1);
        wr(3'd3, 8'h02);
        expect_reg(3'd3, 8'h00, "R9 write one clears cmp");
        wr(3'd1, 8'h01);
        ticks(1);
        @(negedge clk);
        tick    = 1'b1;
        cmp_ack = 1'b1;
        @(negedge clk);
        tick    = 1'b0;
        cmp_ack = 1'b0;
        expect_reg(3'd3, 8'h02, "R9 set beats ack");
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_free_run();
        t_clear_on_cmp();
        t_actions();
        t_force();
        t_block();
        t_flags();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule